// File: doc/BRIEF.md
# Inter-processor interrupt command issuer

This block is the command-register front end of a local interrupt controller. Software writes registers by 8-bit index. In legacy mode the interrupt command is split across two 32-bit halves. In extended mode a single 64-bit write carries the whole command. When a command is accepted, the block decodes its fields and presents the decoded request to a delivery fabric for one cycle. It also resolves the destination shorthand into a per-agent mask that marks self, all agents, or all agents except self.

The block also holds the few registers whose legality depends on the mode: the legacy ID, the logical destination, the destination format, the command high word and the error status. In extended mode it provides a self-interrupt register. Any write that is illegal in the current mode is refused with an error response and has no side effect. Any access to an index the block does not know sets a sticky illegal-address flag. Destination resolution of requests that use the encoded destination is left to downstream logic.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: After reset `req_valid`, `wr_ack`, `wr_err`, `rd_valid`, `rd_err`, `req_mask` and `rd_data` are zero, the error status reads 0, and the ID register read in legacy mode returns `init_id[7:0]` in bits 31:24.
- R2: A command-low write (index 0x30) decodes the vector from data bits 7:0, the delivery mode from 10:8, the destination mode from bit 11, the trigger from bit 15 and the shorthand from bits 19:18.
- R3: In legacy mode the request destination is bits 31:24 of the last value written to index 0x31, zero-extended to 32 bits. Data bits 63:32 of the command-low write are ignored.
- R4: In extended mode the request destination is data bits 63:32 of the command-low write, and those bits also become the stored command high word (read back at index 0x31).
- R5: `req_mask` bit g is set as follows. For shorthand 0 (encoded destination) no bit is set. For shorthand 1 (self) only the bit where g equals the self ID is set. For shorthand 2 (all) every bit is set. For shorthand 3 (all but self) every bit except the self bit is set. A self ID of `AGENTS` or more has no bit.
- R6: The self ID is the full `init_id` in extended mode. In legacy mode it is the 8-bit ID register, which a write to index 0x02 loads from data bits 31:24.
- R7: In extended mode a write to index 0x3F issues a request with vector equal to data bits 7:0, delivery mode 0, destination mode 0, trigger 0, shorthand 1 and destination 0. In legacy mode that write is refused with `wr_err`, issues no request and leaves the error status unchanged.
- R8: In extended mode writes to indices 0x02, 0x0D, 0x0E and 0x31 are refused with `wr_err`. They issue nothing and change neither the stored register nor the error status.
- R9: A write or read at an index the block does not know gives `wr_err` or `rd_err` and sets error status bit 7 (read at index 0x28). The bit stays set until a write to index 0x28 clears it.
- R10: The ID read (0x02) returns `init_id` in extended mode and the ID register in bits 31:24 in legacy mode. The format read (0x0E) returns the format nibble in bits 31:28 with ones below in legacy mode, and returns 0 with `rd_err` in extended mode. The logical read (0x0D) returns the stored byte in bits 31:24 in legacy mode, and `{init_id[19:4],16'b0} | (1 << init_id[3:0])` in extended mode.
- R11: Write and read responses, and the request, appear in the cycle after the access is sampled. Each accepted command write (0x30, or 0x3F in extended mode) gives exactly one single-cycle `req_valid` pulse with `wr_ack`. No refused write gives a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 selects extended mode |
| init_id | input | 32 | Full initial agent ID |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Write register index |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 8 | Read register index |
| wr_ack | output | 1 | Write accepted |
| wr_err | output | 1 | Write refused |
| rd_valid | output | 1 | Read response valid |
| rd_err | output | 1 | Read refused |
| rd_data | output | 64 | Read value |
| req_valid | output | 1 | Single-cycle request pulse |
| req_dest | output | 32 | Encoded destination |
| req_dest_mode | output | 1 | Destination mode |
| req_delivery | output | 3 | Delivery mode |
| req_vector | output | 8 | Interrupt vector |
| req_trigger | output | 1 | Trigger mode |
| req_shorthand | output | 2 | Destination shorthand |
| req_mask | output | AGENTS | Shorthand agent mask |

## Verification
The hardest case to show from the ports is that a write refused in extended mode left the stored register untouched. Extended mode hides the legacy ID and the logical byte. The bench therefore makes the refused writes, switches `ext_mode` back to legacy, and reads the registers to compare them with the values it wrote earlier. The self-mask sweep moves the self ID past the agent count, in both modes, so that shorthands 1 and 3 are seen to produce an empty self bit. The sticky error bit is set by both an unknown write and an unknown read. The bench then makes unrelated legal writes and checks that only a write to the error index clears the bit.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam logic [7:0] IDX_ID     = 8'h02;
  localparam logic [7:0] IDX_LDR    = 8'h0D;
  localparam logic [7:0] IDX_DFR    = 8'h0E;
  localparam logic [7:0] IDX_ESR    = 8'h28;
  localparam logic [7:0] IDX_ICR_LO = 8'h30;
  localparam logic [7:0] IDX_ICR_HI = 8'h31;
  localparam logic [7:0] IDX_SELF   = 8'h3F;

  localparam int ESR_ILLEGAL_BIT = 7;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [31:0] dest;
    logic        dmode;
    logic [2:0]  deliv;
    logic [7:0]  vec;
    logic        trig;
    shorthand_e  sh;
  } ipi_req_t;

endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
(
  input  logic        ext_mode,
  input  logic        wr_en,
  input  logic [7:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [31:0] icr_hi,
  output logic        wr_ok,
  output logic        wr_unknown,
  output logic        issue,
  output ipi_req_t    req
);

  logic ok_c, unk_c, iss_c;

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:20], wr_data[17:16], wr_data[14:12], icr_hi[23:0]};

  always_comb begin
    ok_c  = 1'b0;
    unk_c = 1'b0;
    iss_c = 1'b0;
    req   = '0;
    case (wr_idx)
      IDX_ID, IDX_LDR, IDX_DFR, IDX_ICR_HI: ok_c = !ext_mode;
      IDX_ESR:                              ok_c = 1'b1;
      IDX_ICR_LO: begin
        ok_c      = 1'b1;
        iss_c     = 1'b1;
        req.vec   = wr_data[7:0];
        req.deliv = wr_data[10:8];
        req.dmode = wr_data[11];
        req.trig  = wr_data[15];
        req.sh    = shorthand_e'(wr_data[19:18]);
        req.dest  = ext_mode ? wr_data[63:32] : {24'b0, icr_hi[31:24]};
      end
      IDX_SELF: begin
        ok_c    = ext_mode;
        iss_c   = ext_mode;
        req.vec = wr_data[7:0];
        req.sh  = SH_SELF;
      end
      default: unk_c = 1'b1;
    endcase
  end

  assign wr_ok      = wr_en & ok_c;
  assign wr_unknown = wr_en & unk_c;
  assign issue      = wr_en & iss_c;

endmodule

// File: rtl/ipi_self_mask.sv
module ipi_self_mask
  import ipi_pkg::*;
#(
  parameter int AGENTS = 8
) (
  input  shorthand_e        sh,
  input  logic [31:0]       self_id,
  output logic [AGENTS-1:0] mask
);

  for (genvar g = 0; g < AGENTS; g++) begin : g_bit
    logic is_self;
    assign is_self = (self_id == 32'(g));
    assign mask[g] = (sh == SH_ALL) |
                     ((sh == SH_SELF) & is_self) |
                     ((sh == SH_OTHERS) & !is_self);
  end

endmodule

// File: rtl/ipi_reg_file.sv
module ipi_reg_file
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ext_mode,
  input  logic [31:0] init_id,
  input  logic        wr_en,
  input  logic [7:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic        wr_ok,
  input  logic        wr_unknown,
  input  logic        rd_en,
  input  logic [7:0]  rd_idx,
  output logic [7:0]  id_q,
  output logic [31:0] icr_hi_q,
  output logic        rd_valid,
  output logic        rd_err,
  output logic [63:0] rd_data
);

  logic [7:0]  ldr_q;
  logic [3:0]  dfr_q;
  logic [31:0] icr_lo_q;
  logic [7:0]  esr_q;

  logic [63:0] rd_c;
  logic        rd_err_c, rd_unk_c;
  logic [31:0] ext_ldr;

  assign ext_ldr = {init_id[19:4], 16'b0} | (32'd1 << init_id[3:0]);

  always_comb begin
    rd_c     = '0;
    rd_err_c = 1'b0;
    rd_unk_c = 1'b0;
    case (rd_idx)
      IDX_ID:     rd_c = ext_mode ? {32'b0, init_id} : {32'b0, id_q, 24'b0};
      IDX_LDR:    rd_c = ext_mode ? {32'b0, ext_ldr} : {32'b0, ldr_q, 24'b0};
      IDX_DFR: begin
        if (ext_mode) rd_err_c = 1'b1;
        else          rd_c = {32'b0, dfr_q, 28'hFFF_FFFF};
      end
      IDX_ESR:    rd_c = {56'b0, esr_q};
      IDX_ICR_LO: rd_c = ext_mode ? {icr_hi_q, icr_lo_q} : {32'b0, icr_lo_q};
      IDX_ICR_HI: rd_c = {32'b0, icr_hi_q};
      default: begin
        rd_err_c = 1'b1;
        rd_unk_c = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q     <= init_id[7:0];
      ldr_q    <= '0;
      dfr_q    <= 4'hF;
      icr_lo_q <= '0;
      icr_hi_q <= '0;
      esr_q    <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_idx)
          IDX_ID:     id_q     <= wr_data[31:24];
          IDX_LDR:    ldr_q    <= wr_data[31:24];
          IDX_DFR:    dfr_q    <= wr_data[31:28];
          IDX_ICR_HI: icr_hi_q <= wr_data[31:0];
          IDX_ESR:    esr_q    <= '0;
          IDX_ICR_LO: begin
            icr_lo_q <= wr_data[31:0];
            if (ext_mode) icr_hi_q <= wr_data[63:32];
          end
          default: ;
        endcase
      end
      if (wr_unknown || (rd_en && rd_unk_c)) esr_q[ESR_ILLEGAL_BIT] <= 1'b1;
      rd_valid <= rd_en;
      rd_err   <= rd_en & rd_err_c;
      rd_data  <= rd_en ? rd_c : '0;
    end
  end

  // R9: illegal-address flag only drops on a write to the error index
  a_r9_esr_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(esr_q[ESR_ILLEGAL_BIT]) && !$past(wr_en && wr_idx == IDX_ESR))
      |-> esr_q[ESR_ILLEGAL_BIT]);

  // R10: extended-mode format read is refused with zero data
  a_r10_dfr_ext_err: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(ext_mode && rd_idx == IDX_DFR)) |-> (rd_err && rd_data == 64'd0));

endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
  import ipi_pkg::*;
#(
  parameter int AGENTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic [31:0]       init_id,
  input  logic              wr_en,
  input  logic [7:0]        wr_idx,
  input  logic [63:0]       wr_data,
  input  logic              rd_en,
  input  logic [7:0]        rd_idx,
  output logic              wr_ack,
  output logic              wr_err,
  output logic              rd_valid,
  output logic              rd_err,
  output logic [63:0]       rd_data,
  output logic              req_valid,
  output logic [31:0]       req_dest,
  output logic              req_dest_mode,
  output logic [2:0]        req_delivery,
  output logic [7:0]        req_vector,
  output logic              req_trigger,
  output logic [1:0]        req_shorthand,
  output logic [AGENTS-1:0] req_mask
);

  logic              wr_ok, wr_unknown, issue;
  ipi_req_t          req_c, req_q;
  logic [7:0]        id_q;
  logic [31:0]       icr_hi_q, self_id;
  logic [AGENTS-1:0] mask_c;

  ipi_wr_decode u_dec (
    .ext_mode   (ext_mode),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .icr_hi     (icr_hi_q),
    .wr_ok      (wr_ok),
    .wr_unknown (wr_unknown),
    .issue      (issue),
    .req        (req_c)
  );

  assign self_id = ext_mode ? init_id : {24'b0, id_q};

  ipi_self_mask #(.AGENTS(AGENTS)) u_mask (
    .sh      (req_c.sh),
    .self_id (self_id),
    .mask    (mask_c)
  );

  ipi_reg_file u_regs (
    .clk        (clk),
    .rst        (rst),
    .ext_mode   (ext_mode),
    .init_id    (init_id),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_ok      (wr_ok),
    .wr_unknown (wr_unknown),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .id_q       (id_q),
    .icr_hi_q   (icr_hi_q),
    .rd_valid   (rd_valid),
    .rd_err     (rd_err),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_q     <= '0;
      req_mask  <= '0;
      wr_ack    <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      req_valid <= issue;
      req_q     <= issue ? req_c : '0;
      req_mask  <= issue ? mask_c : '0;
      wr_ack    <= wr_ok;
      wr_err    <= wr_en & !wr_ok;
    end
  end

  assign req_dest      = req_q.dest;
  assign req_dest_mode = req_q.dmode;
  assign req_delivery  = req_q.deliv;
  assign req_vector    = req_q.vec;
  assign req_trigger   = req_q.trig;
  assign req_shorthand = req_q.sh;

  // R11: a request always comes with an accept, never with a refusal
  a_r11_req_with_ack: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (wr_ack && !wr_err));

  // R5: shorthand masks
  a_r5_all_full: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_shorthand == 2'd2) |-> (&req_mask));
  a_r5_self_onehot: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_shorthand == 2'd1) |-> $onehot0(req_mask));
  a_r5_none_empty: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_shorthand == 2'd0) |-> (req_mask == '0));

  // R7: self-interrupt register issues a fixed, edge, self request
  a_r7_self_fields: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(wr_idx == IDX_SELF))
      |-> (req_delivery == 3'd0 && !req_trigger && req_shorthand == 2'd1 && req_dest == 32'd0));

endmodule

// File: tb/ipi_cmd_issuer_test.sv
module ipi_cmd_issuer_test;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b0;
  logic [31:0] init_id = 32'd5;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_idx = '0;
  logic        wr_ack, wr_err, rd_valid, rd_err, req_valid;
  logic [63:0] rd_data;
  logic [31:0] req_dest;
  logic        req_dest_mode, req_trigger;
  logic [2:0]  req_delivery;
  logic [7:0]  req_vector;
  logic [1:0]  req_shorthand;
  logic [N-1:0] req_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  ipi_cmd_issuer #(.AGENTS(N)) uut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .init_id(init_id),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_ack(wr_ack), .wr_err(wr_err), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_data(rd_data), .req_valid(req_valid), .req_dest(req_dest),
    .req_dest_mode(req_dest_mode), .req_delivery(req_delivery),
    .req_vector(req_vector), .req_trigger(req_trigger),
    .req_shorthand(req_shorthand), .req_mask(req_mask)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] idx);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [63:0] exp_mask(input int sh, input logic [31:0] self_id);
    logic [63:0] all, me;
    all = (64'd1 << N) - 64'd1;
    me  = (self_id < N) ? (64'd1 << self_id) : 64'd0;
    case (sh)
      1:       return me;
      2:       return all;
      3:       return all & ~me;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] cmd_lo(input int vec, input int dl, input int dm, input int tr, input int sh);
    return 64'((vec & 255) | ((dl & 7) << 8) | ((dm & 1) << 11) | ((tr & 1) << 15) | ((sh & 3) << 18));
  endfunction

  logic [31:0] icr_hi_model;
  logic [7:0]  legacy_id_model;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state (sampled while reset still active, then after release)
    chk("R1 req_valid", 64'(req_valid), 64'd0);
    chk("R1 wr_ack", 64'(wr_ack), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 req_mask", 64'(req_mask), 64'd0);
    chk("R1 rd_data", rd_data, 64'd0);
    rst = 1'b0;
    do_rd(8'h02);
    chk("R1 id read", rd_data, 64'h0500_0000);
    do_rd(8'h28);
    chk("R1 esr", rd_data, 64'd0);

    // Legacy sweep: R2 R3 R5 R6
    for (int id = 0; id < 10; id++) begin
      logic [7:0] dbyte;
      dbyte = 8'((id * 29 + 3) & 255);
      do_wr(8'h02, 64'(id) << 24);
      chk("R6 id write ack", 64'(wr_ack), 64'd1);
      do_wr(8'h31, {32'hFFFF_FFFF, dbyte, 24'h00ABCD});
      icr_hi_model = {dbyte, 24'h00ABCD};
      for (int sh = 0; sh < 4; sh++) begin
        for (int k = 0; k < 2; k++) begin
          int vec, dl;
          vec = (id * 37 + sh * 11 + k * 101) & 255;
          dl  = (id + sh + k) % 8;
          do_wr(8'h30, {32'hDEAD_0000 | 32'(id), 32'hFFF0_7000} | cmd_lo(vec, dl, k, sh, sh));
          chk("R11 req pulse", 64'(req_valid), 64'd1);
          chk("R2 vector", 64'(req_vector), 64'(vec));
          chk("R2 delivery", 64'(req_delivery), 64'(dl));
          chk("R2 dest mode", 64'(req_dest_mode), 64'(k));
          chk("R2 trigger", 64'(req_trigger), 64'(sh & 1));
          chk("R2 shorthand", 64'(req_shorthand), 64'(sh));
          chk("R3 legacy dest", 64'(req_dest), 64'(dbyte));
          chk("R5 R6 legacy mask", 64'(req_mask), exp_mask(sh, 32'(id)));
        end
      end
      @(negedge clk);
      chk("R11 single pulse", 64'(req_valid), 64'd0);
    end
    legacy_id_model = 8'd9;
    do_wr(8'h0D, 64'h4200_0000);
    do_wr(8'h0E, 64'h0000_0000);

    // Extended sweep: R4 R5 R6
    ext_mode = 1'b1;
    for (int j = 0; j < 6; j++) begin
      logic [31:0] ids [6];
      ids = '{32'd0, 32'd3, 32'd7, 32'd8, 32'd200, 32'h0001_2345};
      init_id = ids[j];
      for (int sh = 0; sh < 4; sh++) begin
        logic [31:0] d;
        d = ids[j] ^ 32'hA5A5_0000 ^ 32'(sh);
        do_wr(8'h30, {d, 32'h0} | cmd_lo(j * 40 + sh, sh, 1, 0, sh));
        chk("R4 ext dest", 64'(req_dest), 64'(d));
        chk("R5 R6 ext mask", 64'(req_mask), exp_mask(sh, ids[j]));
        icr_hi_model = d;
      end
      do_rd(8'h31);
      chk("R4 icr hi stored", rd_data, 64'(icr_hi_model));
      do_rd(8'h02);
      chk("R10 ext id read", rd_data, 64'(ids[j]));
      do_rd(8'h0D);
      chk("R10 ext ldr read", rd_data,
          64'({ids[j][19:4], 16'b0} | (32'd1 << ids[j][3:0])));
    end

    // R7 self register, extended
    init_id = 32'd6;
    do_wr(8'h3F, 64'hFFFF_FFFF_FFFF_FF9C);
    chk("R7 self req", 64'(req_valid), 64'd1);
    chk("R7 self vector", 64'(req_vector), 64'h9C);
    chk("R7 self delivery", 64'(req_delivery), 64'd0);
    chk("R7 self trigger", 64'(req_trigger), 64'd0);
    chk("R7 self dest mode", 64'(req_dest_mode), 64'd0);
    chk("R7 self shorthand", 64'(req_shorthand), 64'd1);
    chk("R7 self dest", 64'(req_dest), 64'd0);
    chk("R7 self mask", 64'(req_mask), 64'h40);

    // R8 extended rejections
    do_wr(8'h02, 64'h7700_0000);
    chk("R8 id refused", 64'({wr_err, wr_ack, req_valid}), 64'b100);
    do_wr(8'h0D, 64'h1100_0000);
    chk("R8 ldr refused", 64'({wr_err, wr_ack, req_valid}), 64'b100);
    do_wr(8'h0E, 64'h0000_0000);
    chk("R8 dfr refused", 64'({wr_err, wr_ack, req_valid}), 64'b100);
    do_wr(8'h31, 64'h1234_5678);
    chk("R8 icr hi refused", 64'({wr_err, wr_ack, req_valid}), 64'b100);
    do_rd(8'h0E);
    chk("R10 ext dfr err", {rd_data[62:0], rd_err}, 64'd1);
    do_rd(8'h28);
    chk("R8 esr untouched", rd_data, 64'd0);
    do_rd(8'h31);
    chk("R8 icr hi unchanged", rd_data, 64'(icr_hi_model));

    // Back to legacy: R7 refusal and R8 state kept
    ext_mode = 1'b0;
    do_rd(8'h02);
    chk("R8 legacy id kept", rd_data, 64'(legacy_id_model) << 24);
    do_rd(8'h0D);
    chk("R8 ldr kept", rd_data, 64'h4200_0000);
    do_rd(8'h0E);
    chk("R8 R10 dfr kept", rd_data, 64'h0FFF_FFFF);
    do_wr(8'h3F, 64'h55);
    chk("R7 legacy self refused", 64'({wr_err, wr_ack, req_valid}), 64'b100);
    do_rd(8'h28);
    chk("R7 legacy esr untouched", rd_data, 64'd0);

    // R9 unknown write, sticky flag, clear
    do_wr(8'h50, 64'h1);
    chk("R9 unknown wr err", 64'({wr_err, wr_ack}), 64'b10);
    do_rd(8'h28);
    chk("R9 esr set", rd_data, 64'h80);
    do_wr(8'h30, cmd_lo(1, 0, 0, 0, 0));
    do_wr(8'h02, 64'h0300_0000);
    do_rd(8'h28);
    chk("R9 esr sticky", rd_data, 64'h80);
    do_wr(8'h28, 64'h0);
    chk("R9 esr clear ack", 64'(wr_ack), 64'd1);
    do_rd(8'h28);
    chk("R9 esr cleared", rd_data, 64'd0);
    do_rd(8'h77);
    chk("R9 unknown rd err", 64'({rd_valid, rd_err}), 64'b11);
    do_rd(8'h28);
    chk("R9 esr set by read", rd_data, 64'h80);
    do_wr(8'h28, 64'h0);

    // R6 legacy self via new ID, R10 legacy id read
    do_rd(8'h02);
    chk("R10 legacy id read", rd_data, 64'h0300_0000);
    do_wr(8'h30, cmd_lo(7, 0, 0, 0, 3));
    chk("R6 others mask", 64'(req_mask), exp_mask(3, 32'd3));

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule